// File: doc/BRIEF.md
# Column Command Spacing Checker

This block sits next to a DRAM command scheduler and rules, every cycle, on whether the scheduler's candidate column command may go out now. A column command is a read or a write. Each of the two may also carry auto-precharge. A command may go out only if its data burst will not overlap the bursts of earlier column commands on the shared data bus and strobe. The block keeps two cycle distances, one since the latest read-type issue and one since the latest write-type issue. It compares each with a minimum spacing that depends on the order of the two commands.

All spacings are computed at elaboration from cycle-count parameters. These are the CAS-to-CAS delay, read latency, write latency, write-to-read recovery and burst length. A burst occupies half its length in clocks, because data moves on both edges. The scheduler presents a candidate and gets back a go/no-go flag and the number of cycles still to wait. It pulses `issue` in the cycle the command is actually sent, and that pulse records the command in the history. A history entry stops constraining new commands once it is older than a configured window. An unknown command code is reported as an error and is never allowed.

Top module: `col_spacing_chk`

## Requirements
- R1: After reset no history exists: the first legal candidate is allowed at once with `wait_cycles` 0.
- R2: A read (code 3'b000) or read with auto-precharge (3'b001) following a read-type issue by d cycles is blocked while d < max(TCCD, BURST_LEN/2), and allowed from that distance on.
- R3: A write (3'b010) or write with auto-precharge (3'b011) following a write-type issue by d cycles is blocked while d < max(TCCD, BURST_LEN/2).
- R4: A read-type candidate following a write-type issue by d cycles is blocked while d < TWL + BURST_LEN/2 + TWTR.
- R5: A write-type candidate following a read-type issue by d cycles is blocked while d < TRL + BURST_LEN/2 - TWL + 2.
- R6: For a valid legal candidate, `wait_cycles` equals the larger of the remaining gaps to the latest read-type and latest write-type issue (0 when none remains), and `allowed` is 1 exactly when it is 0. A later issue of the same type replaces the earlier one.
- R7: Codes with bit 2 set are illegal: with `cand_valid` high they raise `cmd_error`, force `allowed` to 0 and `wait_cycles` to 0, and an `issue` pulse with such a code leaves the history unchanged.
- R8: An issue whose distance has reached HIST no longer constrains any candidate. The distance counters saturate, so arbitrarily long idle periods never bring an old issue back into force.
- R9: With `cand_valid` low, `allowed`, `wait_cycles` and `cmd_error` are all 0 and an `issue` pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the history |
| cand_valid | input | 1 | A candidate column command is presented |
| cand_cmd | input | 3 | Candidate code: 000 read, 001 read+AP, 010 write, 011 write+AP, others illegal |
| issue | input | 1 | The candidate is sent this cycle; record it in the history |
| allowed | output | 1 | Candidate may issue this cycle |
| wait_cycles | output | CNT_W | Cycles still to wait before the candidate clears all spacings |
| cmd_error | output | 1 | Candidate code is illegal |

## Verification
All four ordered pairs are driven at one cycle below and exactly at each spacing, mixing the auto-precharge codes. A design that swapped or merged the pair rules, or measured the distance off by one, releases early or holds one cycle too long. A second instance with a window shorter than the write-to-read spacing shows whether expired entries really stop blocking. A long idle period shows whether the counters wrap instead of saturating. Illegal codes are checked both as candidates and as issue pulses, which exposes a design that blocks correctly but still writes the bad code into its history.

// File: rtl/col_spacing_chk.sv
module col_spacing_chk #(
  parameter int TCCD      = 4,
  parameter int TRL       = 11,
  parameter int TWL       = 8,
  parameter int TWTR      = 6,
  parameter int BURST_LEN = 8,
  parameter int HIST      = 24,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_valid,
  input  logic [2:0]       cand_cmd,
  input  logic             issue,
  output logic             allowed,
  output logic [CNT_W-1:0] wait_cycles,
  output logic             cmd_error
);
  localparam int BURST  = BURST_LEN / 2;
  localparam int RR_GAP = (TCCD > BURST) ? TCCD : BURST;
  localparam int WW_GAP = (TCCD > BURST) ? TCCD : BURST;
  localparam int WR_GAP = TWL + BURST + TWTR;
  localparam int RW_GAP = TRL + BURST - TWL + 2;

  localparam logic [CNT_W-1:0] CMAX   = '1;
  localparam logic [CNT_W-1:0] RR_G   = CNT_W'(RR_GAP);
  localparam logic [CNT_W-1:0] WW_G   = CNT_W'(WW_GAP);
  localparam logic [CNT_W-1:0] WR_G   = CNT_W'(WR_GAP);
  localparam logic [CNT_W-1:0] RW_G   = CNT_W'(RW_GAP);
  localparam logic [CNT_W-1:0] HIST_G = CNT_W'(HIST);

  logic [CNT_W-1:0] since_rd, since_wr;
  logic             rd_seen, wr_seen;

  wire legal = ~cand_cmd[2];
  wire is_wr = cand_cmd[1];
  wire take  = issue & cand_valid & legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rd <= '0;
      rd_seen  <= 1'b0;
    end else if (take && !is_wr) begin
      since_rd <= CNT_W'(1);
      rd_seen  <= 1'b1;
    end else if (since_rd != CMAX) begin
      since_rd <= since_rd + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_wr <= '0;
      wr_seen  <= 1'b0;
    end else if (take && is_wr) begin
      since_wr <= CNT_W'(1);
      wr_seen  <= 1'b1;
    end else if (since_wr != CMAX) begin
      since_wr <= since_wr + 1'b1;
    end
  end

  wire rd_live = rd_seen & (since_rd < HIST_G);
  wire wr_live = wr_seen & (since_wr < HIST_G);

  wire [CNT_W-1:0] need_rd = is_wr ? RW_G : RR_G;
  wire [CNT_W-1:0] need_wr = is_wr ? WW_G : WR_G;

  wire [CNT_W-1:0] rem_rd = (rd_live && need_rd > since_rd) ? need_rd - since_rd : '0;
  wire [CNT_W-1:0] rem_wr = (wr_live && need_wr > since_wr) ? need_wr - since_wr : '0;
  wire [CNT_W-1:0] worst  = (rem_rd > rem_wr) ? rem_rd : rem_wr;

  assign cmd_error   = cand_valid & ~legal;
  assign wait_cycles = (cand_valid && legal) ? worst : '0;
  assign allowed     = cand_valid & legal & (worst == '0);
endmodule

// File: rtl/col_spacing_sva.sv
module col_spacing_sva #(
  parameter int CNT_W  = 6,
  parameter int RR_GAP = 4,
  parameter int WW_GAP = 4,
  parameter int WR_GAP = 18,
  parameter int RW_GAP = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cand_valid,
  input logic [2:0]       cand_cmd,
  input logic             issue,
  input logic             allowed,
  input logic [CNT_W-1:0] wait_cycles,
  input logic             cmd_error
);
  wire cand_rd = cand_valid & (cand_cmd[2:1] == 2'b00);
  wire cand_wr = cand_valid & (cand_cmd[2:1] == 2'b01);

  p_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && cand_cmd[2] |-> cmd_error && !allowed && wait_cycles == '0);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_valid |-> !allowed && !cmd_error && wait_cycles == '0);

  p_rd_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(issue && cand_rd) && cand_rd && (RR_GAP > 1)
    |-> !allowed && wait_cycles >= CNT_W'(RR_GAP - 1));

  p_wr_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(issue && cand_wr) && cand_wr && (WW_GAP > 1)
    |-> !allowed && wait_cycles >= CNT_W'(WW_GAP - 1));

  p_wr_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(issue && cand_wr) && cand_rd && (WR_GAP > 1)
    |-> !allowed && wait_cycles >= CNT_W'(WR_GAP - 1));

  p_rd_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(issue && cand_rd) && cand_wr && (RW_GAP > 1)
    |-> !allowed && wait_cycles >= CNT_W'(RW_GAP - 1));

  p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(cand_valid) && cand_valid && !cand_cmd[2] &&
    $stable(cand_cmd) && !$past(issue) && $past(wait_cycles) != '0
    |-> wait_cycles < $past(wait_cycles));
endmodule

bind col_spacing_chk col_spacing_sva #(
  .CNT_W(CNT_W), .RR_GAP(RR_GAP), .WW_GAP(WW_GAP), .WR_GAP(WR_GAP), .RW_GAP(RW_GAP)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_cmd(cand_cmd),
  .issue(issue), .allowed(allowed), .wait_cycles(wait_cycles), .cmd_error(cmd_error)
);

// File: tb/col_spacing_chk_test.sv
module col_spacing_chk_test;
  localparam int TCCD = 4, TRL = 11, TWL = 8, TWTR = 6, BL = 8;
  localparam int HIST = 24, HIST_W = 10, CNT_W = 6;
  localparam int BUR = BL / 2;
  localparam int RR = (TCCD > BUR) ? TCCD : BUR;
  localparam int WW = (TCCD > BUR) ? TCCD : BUR;
  localparam int WR = TWL + BUR + TWTR;
  localparam int RW = TRL + BUR - TWL + 2;

  logic clk = 0, rst_n = 0, cand_valid = 0, issue = 0;
  logic [2:0] cand_cmd = 3'b000;
  logic allowed, cmd_error, allowed_w, cmd_error_w;
  logic [CNT_W-1:0] wait_cycles, wait_cycles_w;

  col_spacing_chk #(.TCCD(TCCD), .TRL(TRL), .TWL(TWL), .TWTR(TWTR), .BURST_LEN(BL),
                    .HIST(HIST), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_cmd(cand_cmd), .issue(issue),
    .allowed(allowed), .wait_cycles(wait_cycles), .cmd_error(cmd_error));

  col_spacing_chk #(.TCCD(TCCD), .TRL(TRL), .TWL(TWL), .TWTR(TWTR), .BURST_LEN(BL),
                    .HIST(HIST_W), .CNT_W(CNT_W)) uut_win (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_cmd(cand_cmd), .issue(issue),
    .allowed(allowed_w), .wait_cycles(wait_cycles_w), .cmd_error(cmd_error_w));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, last_rd = 0, last_wr = 0;
  bit seen_rd = 0, seen_wr = 0, done = 0;

  function automatic int rem(int need, bit seen, int last, int hist);
    int d = cyc - last;
    if (!seen || d >= hist) return 0;
    return (need > d) ? need - d : 0;
  endfunction

  function automatic int exp_wait(bit v, logic [2:0] c, int hist);
    int a, b;
    if (!v || c[2]) return 0;
    a = rem(c[1] ? RW : RR, seen_rd, last_rd, hist);
    b = rem(c[1] ? WW : WR, seen_wr, last_wr, hist);
    return (a > b) ? a : b;
  endfunction

  task automatic check_one(string req, string tag, bit ga, int gw, bit ge, int hist);
    int ew = exp_wait(cand_valid, cand_cmd, hist);
    bit ee = cand_valid && cand_cmd[2];
    bit ea = cand_valid && !cand_cmd[2] && ew == 0;
    checks++;
    if (ga !== ea || gw != ew || ge !== ee) begin
      errors++;
      $display("FAIL %s %s cyc=%0d cmd=%b allowed=%0d exp %0d wait=%0d exp %0d err=%0d exp %0d",
               req, tag, cyc, cand_cmd, ga, ea, gw, ew, ge, ee);
    end
  endtask

  task automatic step(bit v, logic [2:0] c, bit iss, string req);
    @(negedge clk);
    cand_valid = v; cand_cmd = c; issue = iss;
    #1;
    if (rst_n) begin
      check_one(req, "main", allowed, int'(wait_cycles), cmd_error, HIST);
      check_one(req, "win", allowed_w, int'(wait_cycles_w), cmd_error_w, HIST_W);
    end
    @(posedge clk);
    if (!rst_n) begin
      seen_rd = 0; seen_wr = 0;
    end else if (iss && v && !c[2]) begin
      if (c[1]) begin last_wr = cyc; seen_wr = 1; end
      else begin last_rd = cyc; seen_rd = 1; end
    end
    cyc++;
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(0, 3'b000, 0, req);
  endtask

  task automatic pair(logic [2:0] first, logic [2:0] second, int d, string req);
    step(1, first, 1, req);
    idle(d - 1, req);
    step(1, second, 0, req);
    idle(30, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired: actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle(3, "reset");
    @(negedge clk); rst_n = 1;
    step(1, 3'b000, 0, "R1");
    step(1, 3'b011, 0, "R1");
    idle(2, "R9");
    step(0, 3'b010, 1, "R9");
    step(1, 3'b010, 0, "R9");

    for (int k = 0; k < 2; k++) begin
      pair(3'b000, 3'b001, RR - 1 + k, "R2");
      pair(3'b011, 3'b010, WW - 1 + k, "R3");
      pair(3'b010, 3'b001, WR - 1 + k, "R4");
      pair(3'b001, 3'b011, RW - 1 + k, "R5");
    end

    step(1, 3'b000, 1, "R6");
    step(1, 3'b000, 1, "R6");
    idle(2, "R6");
    step(1, 3'b010, 1, "R6");
    for (int i = 0; i < 20; i++) step(1, 3'b001, 0, "R6");
    idle(30, "R6");

    step(1, 3'b101, 1, "R7");
    step(1, 3'b000, 0, "R7");
    step(1, 3'b110, 1, "R7");
    step(1, 3'b010, 0, "R7");
    step(1, 3'b111, 0, "R7");
    idle(30, "R7");

    pair(3'b010, 3'b000, HIST_W + 2, "R8");
    step(1, 3'b000, 1, "R8");
    idle(100, "R8");
    step(1, 3'b010, 0, "R8");
    step(1, 3'b011, 1, "R8");
    idle(100, "R8");
    step(1, 3'b000, 0, "R8");

    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 4) != 0;
      logic [2:0] c = 3'($urandom % 6);
      bit iss = v && (($urandom % 3) == 0);
      step(v, c, iss, "R6");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule